// File: doc/BRIEF.md
# Indirect Codec Control Register File

This block is the control register file of an audio codec, placed on a simple 32-bit bus with separate read and write strobes. It exposes sixteen word-wide direct registers. Behind them sit thirty-two byte-wide indirect registers, which software reaches in two steps. First it writes a selector into direct word 0. Then it reads or writes the data window at direct word 1.

A few locations follow their own rules:

- One indirect entry can be written but always reads as zero.
- Two indirect entries cannot be changed by the bus, and one of them holds a fixed version code.
- One indirect entry keeps a fixed pattern and takes only one writable bit from the bus.
- Direct word 2 is locked at zero.
- Direct word 4 keeps only its low seven bits. When bit 0 of a write to it is set, every other register returns to its reset value while the masked write is still stored.

Read data is registered. It appears one cycle after the read strobe and holds until the next read.

Top module: `codec_ctl_regs`

## Requirements
- R1: After reset every direct word reads 0. Every indirect entry reads 0 except entry 12, which reads 0x8A, and entry 25, which reads 0xA0.
- R2: The word selected is byte address bits [5:2]. Address bits [7:6] and [1:0] are ignored. Direct words other than 1, 2 and 4 store and return all 32 written bits.
- R3: The low 5 bits of direct word 0 pick the indirect entry. A write to word 1 stores wdata[7:0] in that entry. A read of word 1 returns the entry zero-extended to 32 bits. Word 0 itself reads back all 32 bits.
- R4: A read of indirect entry 3 through word 1 returns 0, whatever was written to it.
- R5: Writes through word 1 to indirect entries 11 and 25 have no effect.
- R6: A write through word 1 to indirect entry 12 stores (wdata & 0x40) | 0x8A.
- R7: Writes to direct word 2 have no effect, and it reads 0.
- R8: A write to direct word 4 stores wdata & 0x7F, whether or not bit 0 is set.
- R9: A write to direct word 4 with wdata[0] = 1 returns every other direct word and every indirect entry to its R1 value in the same edge. With wdata[0] = 0 nothing else changes.
- R10: rdata is loaded on the clock edge where rd_en is high. It changes on no other edge, and the active-low reset clears it to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for one cycle |
| rd_en | input | 1 | Read strobe for one cycle |
| addr | input | 8 | Byte address; bits [5:2] select the word |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |

## Verification
The assertions assume that the bus never raises the read and write strobes in the same cycle. They also assume that the strobes and address are stable around the rising edge. The stimulus meets both conditions: every bus operation is driven on the falling edge and clears the other strobe before raising its own. The checks on the locked entries, the masked control word and the write-only entry assume that reset has been applied before the first access. The bench therefore holds rst_n low for several edges before any traffic.

// File: rtl/codec_regs_pkg.sv
// Package: shared constants and per-entry rules of the codec control register file.
// Assumes: exactly one access per cycle; indices below are fixed by the software map.
package codec_regs_pkg;

    // Default geometry
    localparam int DIR_COUNT_D  = 16;
    localparam int IND_COUNT_D  = 32;
    localparam int DATA_W_D     = 32;
    localparam int IND_W_D      = 8;
    localparam int ADDR_W_D     = 8;

    // Direct word roles
    localparam int SEL_WORD     = 0;
    localparam int WIN_WORD     = 1;
    localparam int LOCK_WORD    = 2;
    localparam int CTL_WORD     = 4;
    localparam int CTL_KEEP_W   = 7;

    // Indirect entry roles
    localparam int HIDDEN_ENTRY = 3;
    localparam int FROZEN_ENTRY = 11;
    localparam int MIXED_ENTRY  = 12;
    localparam int VER_ENTRY    = 25;

    localparam logic [7:0] MIXED_FIXED = 8'h8A;
    localparam logic [7:0] MIXED_KEEP  = 8'h40;
    localparam logic [7:0] VER_CODE    = 8'hA0;

    // Write behaviour class of each indirect entry
    typedef enum logic [1:0] {
        ENT_PLAIN  = 2'd0,
        ENT_FROZEN = 2'd1,
        ENT_MIXED  = 2'd2
    } ent_kind_e;

    // Returns the write class of entry i
    function automatic ent_kind_e ent_kind(input int i);
        if (i == FROZEN_ENTRY || i == VER_ENTRY) return ENT_FROZEN;
        if (i == MIXED_ENTRY)                    return ENT_MIXED;
        return ENT_PLAIN;
    endfunction

    // Returns the reset value of entry i
    function automatic logic [7:0] ent_reset(input int i);
        if (i == MIXED_ENTRY) return MIXED_FIXED;
        if (i == VER_ENTRY)   return VER_CODE;
        return 8'h00;
    endfunction

endpackage

// File: rtl/cr_addr_decode.sv
// Module: byte-address decoder. It turns the byte address into a word index and
// one write pulse per direct word.
// Assumes: ADDR_W >= log2(DIR_COUNT) + 2; bits outside the word field are don't-care.
module cr_addr_decode #(
    parameter int ADDR_W    = 8,
    parameter int DIR_COUNT = 16,
    localparam int SEL_W    = $clog2(DIR_COUNT)
) (
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 wr_en,
    output logic [SEL_W-1:0]     word_sel,
    output logic [DIR_COUNT-1:0] word_wr
);

    logic unused_addr_bits;
    assign unused_addr_bits = ^{addr[ADDR_W-1:SEL_W+2], addr[1:0]};

    // Word index taken from the address field above the byte lanes
    assign word_sel = addr[SEL_W+1:2];

    // One-hot write pulse per direct word
    always_comb begin
        word_wr = '0;
        for (int i = 0; i < DIR_COUNT; i++) begin
            word_wr[i] = wr_en && (word_sel == SEL_W'(i));
        end
    end

endmodule

// File: rtl/cr_direct_regs.sv
// Module: direct word registers. Word 0 is the indirect selector; word 1 is the
// window (no storage here); word 2 is locked at zero; word 4 keeps 7 bits and its
// bit 0 requests a soft reset. Every other word is a full-width register.
// Assumes: word_wr is one-hot or zero; synchronous active-low reset.
module cr_direct_regs
    import codec_regs_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int DIR_COUNT = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [DIR_COUNT-1:0] word_wr,
    input  logic [DATA_W-1:0]    wdata,
    output logic                 soft_rst,
    output logic [DATA_W-1:0]    dir_q [DIR_COUNT]
);

    localparam logic [DATA_W-1:0] CtlMask = DATA_W'((1 << CTL_KEEP_W) - 1);

    // Soft reset request: control word written with bit 0 set
    assign soft_rst = word_wr[CTL_WORD] && wdata[0];

    for (genvar i = 0; i < DIR_COUNT; i++) begin : g_word
        if (i == WIN_WORD || i == LOCK_WORD) begin : g_nostore
            // No storage: window data comes from the indirect file, locked word is zero
            assign dir_q[i] = '0;
        end else if (i == CTL_WORD) begin : g_ctl
            // Control word: masked store, the triggering write survives soft reset
            always_ff @(posedge clk) begin
                if (!rst_n)          dir_q[i] <= '0;
                else if (word_wr[i]) dir_q[i] <= wdata & CtlMask;
            end
        end else begin : g_plain
            // Plain word: full-width store, cleared by soft reset
            always_ff @(posedge clk) begin
                if (!rst_n || soft_rst) dir_q[i] <= '0;
                else if (word_wr[i])    dir_q[i] <= wdata;
            end
        end
    end

    // R8: control word never holds bits above the kept field
    p_ctl_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
        word_wr[CTL_WORD] |=> (dir_q[CTL_WORD][DATA_W-1:CTL_KEEP_W] == '0));

    // R9: a soft reset clears the highest plain word on the next edge
    p_soft_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (dir_q[DIR_COUNT-1] == '0));

    // R7: locked word stays zero whenever it is written
    p_locked_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        word_wr[LOCK_WORD] |=> (dir_q[LOCK_WORD] == '0));

endmodule

// File: rtl/cr_indirect_regs.sv
// Module: byte-wide indirect entries behind the window. Each entry follows its
// class: plain store, frozen (bus writes dropped), or mixed (fixed pattern plus
// one writable bit). The read path hides the write-only entry.
// Assumes: a soft reset and a window write never coincide.
module cr_indirect_regs
    import codec_regs_pkg::*;
#(
    parameter int IND_COUNT = 32,
    parameter int IND_W     = 8,
    localparam int SEL_W    = $clog2(IND_COUNT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             win_wr,
    input  logic [SEL_W-1:0] sel,
    input  logic [IND_W-1:0] wbyte,
    output logic [IND_W-1:0] rd_byte
);

    logic [IND_W-1:0] ent_q [IND_COUNT];

    for (genvar i = 0; i < IND_COUNT; i++) begin : g_ent
        localparam logic [IND_W-1:0] RstVal = IND_W'(ent_reset(i));
        logic hit;
        assign hit = win_wr && (sel == SEL_W'(i));

        if (ent_kind(i) == ENT_FROZEN) begin : g_frozen
            // Frozen entry: only reset loads it
            always_ff @(posedge clk) begin
                if (!rst_n || soft_rst) ent_q[i] <= RstVal;
            end
        end else if (ent_kind(i) == ENT_MIXED) begin : g_mixed
            // Mixed entry: fixed pattern merged with the one writable bit
            always_ff @(posedge clk) begin
                if (!rst_n || soft_rst) ent_q[i] <= RstVal;
                else if (hit)
                    ent_q[i] <= (wbyte & IND_W'(MIXED_KEEP)) | IND_W'(MIXED_FIXED);
            end
        end else begin : g_plain
            // Plain entry: stores the written byte
            always_ff @(posedge clk) begin
                if (!rst_n || soft_rst) ent_q[i] <= RstVal;
                else if (hit)           ent_q[i] <= wbyte;
            end
        end
    end

    // Read selection, with the write-only entry masked to zero
    always_comb begin
        if (sel == SEL_W'(HIDDEN_ENTRY)) rd_byte = '0;
        else                             rd_byte = ent_q[sel];
    end

    // R6: the mixed entry keeps its fixed bits after any write
    p_mixed_fixed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (win_wr && sel == SEL_W'(MIXED_ENTRY)) |=>
        ((ent_q[MIXED_ENTRY] & ~IND_W'(MIXED_KEEP)) == IND_W'(MIXED_FIXED)));

    // R5: a window write to the version entry leaves it unchanged
    p_ver_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (win_wr && sel == SEL_W'(VER_ENTRY)) |=> $stable(ent_q[VER_ENTRY]));

    // R9: soft reset restores the version code
    p_soft_ver_r9: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (ent_q[VER_ENTRY] == IND_W'(VER_CODE)));

endmodule

// File: rtl/codec_ctl_regs.sv
// Module: top of the codec control register file. It ties the address decoder,
// the direct words and the indirect entries together and registers read data.
// Assumes: rd_en and wr_en are never high together; synchronous active-low reset.
module codec_ctl_regs
    import codec_regs_pkg::*;
#(
    parameter int ADDR_W    = ADDR_W_D,
    parameter int DATA_W    = DATA_W_D,
    parameter int DIR_COUNT = DIR_COUNT_D,
    parameter int IND_COUNT = IND_COUNT_D,
    parameter int IND_W     = IND_W_D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int DSEL_W = $clog2(DIR_COUNT);
    localparam int ISEL_W = $clog2(IND_COUNT);

    logic [DSEL_W-1:0]    word_sel;
    logic [DIR_COUNT-1:0] word_wr;
    logic                 soft_rst;
    logic [DATA_W-1:0]    dir_q [DIR_COUNT];
    logic [ISEL_W-1:0]    ent_sel;
    logic [IND_W-1:0]     rd_byte;
    logic [DATA_W-1:0]    rd_next;
    logic                 unused_sel_hi;

    cr_addr_decode #(.ADDR_W(ADDR_W), .DIR_COUNT(DIR_COUNT)) u_dec (
        .addr     (addr),
        .wr_en    (wr_en),
        .word_sel (word_sel),
        .word_wr  (word_wr)
    );

    cr_direct_regs #(.DATA_W(DATA_W), .DIR_COUNT(DIR_COUNT)) u_dir (
        .clk      (clk),
        .rst_n    (rst_n),
        .word_wr  (word_wr),
        .wdata    (wdata),
        .soft_rst (soft_rst),
        .dir_q    (dir_q)
    );

    // Entry selector: low bits of the selector word
    assign ent_sel       = dir_q[SEL_WORD][ISEL_W-1:0];
    assign unused_sel_hi = ^dir_q[SEL_WORD][DATA_W-1:ISEL_W];

    cr_indirect_regs #(.IND_COUNT(IND_COUNT), .IND_W(IND_W)) u_ind (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .win_wr   (word_wr[WIN_WORD]),
        .sel      (ent_sel),
        .wbyte    (wdata[IND_W-1:0]),
        .rd_byte  (rd_byte)
    );

    // Read mux: window returns the zero-extended entry, others the stored word
    always_comb begin
        if (word_sel == DSEL_W'(WIN_WORD)) rd_next = DATA_W'(rd_byte);
        else                               rd_next = dir_q[word_sel];
    end

    // Read data register, loaded only on a read strobe
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_next;
    end

    // R10: read data holds when no read is strobed
    p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

    // R4: a window read of the write-only entry returns zero
    p_hidden_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && word_sel == DSEL_W'(WIN_WORD) && ent_sel == ISEL_W'(HIDDEN_ENTRY))
        |=> (rdata == '0));

    // R3: window reads never carry bits above the entry width
    p_win_zext_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && word_sel == DSEL_W'(WIN_WORD)) |=> (rdata[DATA_W-1:IND_W] == '0));

    // R7: a read of the locked word returns zero
    p_lock_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && word_sel == DSEL_W'(LOCK_WORD)) |=> (rdata == '0));

endmodule

// File: tb/tb_codec_ctl_regs.sv
// Scoreboard bench: read tasks queue expected words, a monitor compares them.
module tb_codec_ctl_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] exp_q [$];
    string       tag_q [$];
    logic        rd_seen = 1'b0;

    always #2.5 clk = ~clk;

    codec_ctl_regs dut (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata)
    );

    // Compare one value and count it
    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b1; addr = a; wdata = d;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b1; addr = a;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            wr_en = 1'b0; rd_en = 1'b0;
        end
    endtask

    task automatic ind_wr(input int idx, input logic [31:0] d);
        wr(8'h00, 32'(idx));
        wr(8'h04, d);
    endtask

    task automatic ind_rd(input int idx, input logic [31:0] e, input string tag);
        wr(8'h00, 32'(idx));
        rd(8'h04, e, tag);
    endtask

    // Expected window read after writing byte w to entry i (R3..R6 rules)
    function automatic logic [31:0] ind_exp(input int i, input logic [7:0] w);
        if (i == 3)  return 32'h0;
        if (i == 11) return 32'h0;
        if (i == 25) return 32'hA0;
        if (i == 12) return 32'((w & 8'h40) | 8'h8A);
        return 32'(w);
    endfunction

    // Reset value seen through the window (R1, with R4 hiding entry 3)
    function automatic logic [31:0] ind_rst(input int i);
        if (i == 12) return 32'h8A;
        if (i == 25) return 32'hA0;
        return 32'h0;
    endfunction

    // Monitor: a read strobed at an edge is compared on the following falling edge
    always @(posedge clk) rd_seen <= rd_en && rst_n;

    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R10: actual 0x%08h expected no read result", rdata);
            end else begin
                check(tag_q.pop_front(), rdata, exp_q.pop_front());
            end
        end
    end

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        check("R10 rdata after reset", rdata, 32'h0);

        // R1: reset values of all direct words and indirect entries
        for (int k = 0; k < 16; k++) if (k != 1) rd(8'(k * 4), 32'h0, "R1 direct reset");
        for (int i = 0; i < 32; i++) ind_rd(i, ind_rst(i), "R1 indirect reset");
        ind_rd(3, 32'h0, "R4 hidden entry after reset");

        // R2: full-width words, written with aliased address bits
        for (int k = 3; k < 16; k++) begin
            if (k != 4) wr(8'(k * 4) | 8'hC1, 32'hA5000000 ^ (32'(k) * 32'h01010101));
        end
        for (int k = 3; k < 16; k++) begin
            if (k != 4) rd(8'(k * 4), 32'hA5000000 ^ (32'(k) * 32'h01010101), "R2 word store");
        end

        // R3: selector uses low 5 bits, window stores low byte, zero-extends on read
        wr(8'h00, 32'hFFFFFFE7);
        wr(8'h04, 32'h123456C3);
        rd(8'h04, 32'h000000C3, "R3 window read");
        rd(8'h00, 32'hFFFFFFE7, "R3 selector full width");

        // R3..R6: fill every entry, read back with per-entry rules
        for (int i = 0; i < 32; i++) ind_wr(i, 32'hFFFFFF00 | 32'(8'(i * 7 + 17)));
        for (int i = 0; i < 32; i++) ind_rd(i, ind_exp(i, 8'(i * 7 + 17)), "R3 entry pattern");

        // R4: write-only entry
        ind_wr(3, 32'h55);
        ind_rd(3, 32'h0, "R4 hidden entry read");

        // R5: frozen entries
        ind_wr(11, 32'hFF);
        ind_rd(11, 32'h0, "R5 entry 11 unchanged");
        ind_wr(25, 32'h00);
        ind_rd(25, 32'hA0, "R5 entry 25 unchanged");

        // R6: mixed entry
        ind_wr(12, 32'hFF);
        ind_rd(12, 32'hCA, "R6 mixed with bit set");
        ind_wr(12, 32'h00);
        ind_rd(12, 32'h8A, "R6 mixed with bit clear");
        ind_wr(12, 32'h40);
        ind_rd(12, 32'hCA, "R6 mixed only bit 6");

        // R7: locked word
        wr(8'h08, 32'hDEADBEEF);
        rd(8'h08, 32'h0, "R7 locked word");

        // R8 and R9 negative: masked store without reset
        wr(8'h10, 32'hFFFFFFFE);
        rd(8'h10, 32'h0000007E, "R8 control mask");
        rd(8'h14, 32'hA5000000 ^ (32'd5 * 32'h01010101), "R9 no reset when bit0 clear");
        ind_rd(7, ind_exp(7, 8'(7 * 7 + 17)), "R9 entry kept when bit0 clear");

        // R10: rdata holds across idle cycles and writes
        rd(8'h3C, 32'hA5000000 ^ (32'd15 * 32'h01010101), "R10 read");
        idle(3);
        check("R10 hold idle", rdata, 32'hA5000000 ^ (32'd15 * 32'h01010101));
        wr(8'h3C, 32'h0BADF00D);
        idle(2);
        check("R10 hold after write", rdata, 32'hA5000000 ^ (32'd15 * 32'h01010101));

        // R9: soft reset through control word bit 0
        wr(8'h00, 32'h7);
        wr(8'h10, 32'hFFFFFF81);
        rd(8'h10, 32'h00000001, "R8 control store on soft reset");
        rd(8'h00, 32'h0, "R9 selector cleared");
        rd(8'h14, 32'h0, "R9 word 5 cleared");
        rd(8'h3C, 32'h0, "R9 word 15 cleared");
        rd(8'h04, 32'h0, "R9 entry 0 cleared");
        ind_rd(7, 32'h0, "R9 entry 7 cleared");
        ind_rd(12, 32'h8A, "R9 entry 12 restored");
        ind_rd(25, 32'hA0, "R9 entry 25 restored");
        ind_rd(20, 32'h0, "R9 entry 20 cleared");

        idle(4);
        if (exp_q.size() != 0) begin
            checks++; errors++;
            $display("FAIL R10: actual %0d pending expected 0 pending", exp_q.size());
        end
        finish_run();
    end

endmodule